// File: doc/BRIEF.md
# Embedded Word-Boundary Serializer

This block turns a stream of 24-bit parallel words into a serial frame on two lines: a data line and a serial clock. It runs from one internal clock at twice the serial bit rate, so each serial bit lasts two internal cycles: a low half and a high half of the serial clock. Every word becomes a 26-bit frame. The 24 data bits go out least significant bit first. Two boundary bits follow them, both derived from the word's most significant bit.

The receiver needs no framing wire. Inside the data portion of a frame, the data line changes only while the serial clock is low. At the end of the frame, the serial clock drops its low halves for the two boundary bits, and the data line toggles twice while the clock is held high. This clock-high transition never occurs between data bits, so it marks the word edge without ambiguity.

Words enter through a valid/ready handshake. `in_ready` depends only on the block's state and never on `in_valid`. It is high while the line is idle and in the final internal cycle of a frame. A word transfers on a clock edge where both signals are high. The word is captured at that edge, so `in_data` may change as soon as the transfer is done. If `in_valid` stays high, frames follow one another with no gap. A source that is not ready simply leaves the line idle. The enable input stops transmission immediately.

Top module: `ewb_serializer`

## Requirements
- R1: A frame spans 52 `clk` cycles, two per serial bit. Frame bits 1 to 24 carry `in_data[0]` through `in_data[23]` in that order.
- R2: Frame bit 25 equals the complement of `in_data[23]` of the transferred word.
- R3: Frame bit 26 equals `in_data[23]` of the transferred word.
- R4: During each data bit, `sclk_o` is low in the first cycle and high in the second. During both boundary bits, `sclk_o` stays high. The high half of bit 24 and the two boundary bits therefore form one unbroken high stretch.
- R5: Within bits 1 to 24, `sdat_o` changes only on the edge where `sclk_o` falls. At the start of bits 25 and 26, `sdat_o` changes while `sclk_o` stays high.
- R6: `in_ready` is low from the cycle after a transfer until the last cycle of that frame. The frame carries the word present at the transfer edge, whatever `in_data` does afterwards.
- R7: If `in_valid` is held high, `in_ready` rises in the 52nd cycle of a frame, and the next frame starts with no idle cycle in between.
- R8: When no word is offered at the end of a frame, the line idles with `sclk_o` high and `sdat_o` low, and `in_ready` stays high.
- R9: While `en` is low, `in_ready` is low, no word is accepted, and from the next edge `sclk_o` is high and `sdat_o` is low. A frame in progress is dropped.
- R10: After reset, `sclk_o` is high, `sdat_o` is low, and `in_ready` follows `en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at twice the serial bit rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Transmit enable; low forces the line idle |
| in_valid | input | 1 | A word is offered on in_data |
| in_ready | output | 1 | The block takes a word on this edge |
| in_data | input | 24 | Parallel word |
| sclk_o | output | 1 | Shaped serial clock, registered |
| sdat_o | output | 1 | Serial data, registered |

## Verification
The bench sends frames built from several kinds of word. Asymmetric words expose bit order and off-by-one shifts. Words with the top bit set and words with it clear check both polarities of the boundary pair. All-zero and all-ones words leave the boundary toggles as the only data transitions, so any stray data edge shows up at once. Back-to-back frames with `in_data` changed after each transfer test capture timing and the gapless restart. An idle gap and an enable drop in the middle of a frame test the idle level and the abort.

// File: rtl/ewb_ser_pkg.sv
package ewb_ser_pkg;
  // Bits appended after the data word in each frame.
  localparam int BOUNDARY_BITS = 2;
  // Internal clock cycles per serial bit (low half, high half).
  localparam int HALVES_PER_BIT = 2;

  function automatic int frame_bits(input int data_w);
    return data_w + BOUNDARY_BITS;
  endfunction
endpackage

// File: rtl/ewb_ser_seq.sv
// Frame sequencer: tracks bit index and half-bit phase, runs the handshake.
module ewb_ser_seq
  import ewb_ser_pkg::*;
#(
  parameter int DATA_W = 24,
  localparam int FRAME_W = frame_bits(DATA_W),
  localparam int IW = $clog2(FRAME_W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          load,
  output logic          shift,
  output logic          clear,
  output logic          nxt_active,
  output logic [IW-1:0] nxt_bit,
  output logic          nxt_half
);
  localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_W - 1);

  logic          act_q;
  logic [IW-1:0] bit_q;
  logic          half_q;
  logic          frame_end;

  assign frame_end = act_q & half_q & (bit_q == LAST_IDX);
  assign in_ready  = en & (~act_q | frame_end);
  assign load      = in_ready & in_valid;
  assign shift     = en & act_q & half_q & ~frame_end;
  assign clear     = ~en | (in_ready & ~in_valid);

  always_comb begin
    nxt_active = act_q;
    nxt_bit    = bit_q;
    nxt_half   = half_q;
    if (!en) begin
      nxt_active = 1'b0;
      nxt_bit    = '0;
      nxt_half   = 1'b0;
    end else if (in_ready) begin
      nxt_active = in_valid;
      nxt_bit    = '0;
      nxt_half   = 1'b0;
    end else if (!half_q) begin
      nxt_half   = 1'b1;
    end else begin
      nxt_bit    = bit_q + 1'b1;
      nxt_half   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      bit_q  <= '0;
      half_q <= 1'b0;
    end else begin
      act_q  <= nxt_active;
      bit_q  <= nxt_bit;
      half_q <= nxt_half;
    end
  end
endmodule

// File: rtl/ewb_ser_shift.sv
// Frame register: loads word plus boundary pair, shifts LSB first; bit 0 is the line.
module ewb_ser_shift
  import ewb_ser_pkg::*;
#(
  parameter int DATA_W = 24,
  localparam int FRAME_W = frame_bits(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic              clear,
  input  logic [DATA_W-1:0] in_data,
  output logic              sdat
);
  logic [FRAME_W-1:0] frm_q;
  logic               msb;

  assign msb  = in_data[DATA_W-1];
  assign sdat = frm_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_q <= '0;
    end else if (clear) begin
      frm_q <= '0;
    end else if (load) begin
      // last bit sent equals MSB, the one before it is its complement
      frm_q <= {msb, ~msb, in_data};
    end else if (shift) begin
      frm_q <= {1'b0, frm_q[FRAME_W-1:1]};
    end
  end
endmodule

// File: rtl/ewb_ser_clkgen.sv
// Serial clock shaper: registered from next state so the pin cannot glitch.
module ewb_ser_clkgen
  import ewb_ser_pkg::*;
#(
  parameter int DATA_W = 24,
  localparam int FRAME_W = frame_bits(DATA_W),
  localparam int IW = $clog2(FRAME_W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          nxt_active,
  input  logic [IW-1:0] nxt_bit,
  input  logic          nxt_half,
  output logic          sclk
);
  localparam logic [IW-1:0] FIRST_BOUNDARY = IW'(DATA_W);

  logic in_boundary;
  assign in_boundary = (nxt_bit >= FIRST_BOUNDARY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk <= 1'b1;
    else        sclk <= ~nxt_active | nxt_half | in_boundary;
  end
endmodule

// File: rtl/ewb_serializer.sv
module ewb_serializer
  import ewb_ser_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              sclk_o,
  output logic              sdat_o
);
  localparam int FRAME_W = frame_bits(DATA_W);
  localparam int IW = $clog2(FRAME_W);

  logic          load, shift, clear;
  logic          nxt_active, nxt_half;
  logic [IW-1:0] nxt_bit;

  ewb_ser_seq #(.DATA_W(DATA_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .en(en), .in_valid(in_valid),
    .in_ready(in_ready), .load(load), .shift(shift), .clear(clear),
    .nxt_active(nxt_active), .nxt_bit(nxt_bit), .nxt_half(nxt_half)
  );

  ewb_ser_shift #(.DATA_W(DATA_W)) shf_i (
    .clk(clk), .rst_n(rst_n), .load(load), .shift(shift), .clear(clear),
    .in_data(in_data), .sdat(sdat_o)
  );

  ewb_ser_clkgen #(.DATA_W(DATA_W)) ckg_i (
    .clk(clk), .rst_n(rst_n), .nxt_active(nxt_active), .nxt_bit(nxt_bit),
    .nxt_half(nxt_half), .sclk(sclk_o)
  );
endmodule

// File: rtl/ewb_serializer_chk.sv
module ewb_serializer_chk
  import ewb_ser_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic in_valid,
  input logic in_ready,
  input logic sclk_o,
  input logic sdat_o
);
  localparam int SPAN = HALVES_PER_BIT * frame_bits(DATA_W);
  localparam int PW = $clog2(SPAN);
  localparam logic [PW-1:0] LAST_POS = PW'(SPAN - 1);
  localparam logic [PW-1:0] B1_POS = PW'(2 * DATA_W);
  localparam logic [PW-1:0] B2_POS = PW'(2 * DATA_W + 2);

  // Independent frame-position tracker built only from port activity.
  logic          trk_act;
  logic [PW-1:0] pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trk_act <= 1'b0;
      pos     <= '0;
    end else if (!en) begin
      trk_act <= 1'b0;
      pos     <= '0;
    end else if (in_valid && in_ready) begin
      trk_act <= 1'b1;
      pos     <= '0;
    end else if (trk_act && pos == LAST_POS) begin
      trk_act <= 1'b0;
    end else if (trk_act) begin
      pos <= pos + 1'b1;
    end
  end

  assert_sclk_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trk_act && pos < B1_POS) |-> (sclk_o == pos[0]));

  assert_boundary_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trk_act && pos >= B1_POS) |-> sclk_o);

  assert_data_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trk_act && pos < B1_POS && sclk_o && $past(sclk_o)) |-> $stable(sdat_o));

  assert_first_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trk_act && pos == B1_POS) |-> (sclk_o && sdat_o != $past(sdat_o)));

  assert_second_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trk_act && pos == B2_POS) |-> (sclk_o && sdat_o != $past(sdat_o)));

  assert_busy_not_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trk_act && pos != LAST_POS) |-> !in_ready);

  assert_line_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !trk_act |-> (sclk_o && !sdat_o));

  assert_disable_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (sclk_o && !sdat_o));

  assert_ready_needs_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> en);
endmodule

bind ewb_serializer ewb_serializer_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .in_valid(in_valid),
  .in_ready(in_ready), .sclk_o(sclk_o), .sdat_o(sdat_o)
);

// File: tb/ewb_serializer_tb.sv
module ewb_serializer_tb_top;
  localparam int CLK_P = 10;
  localparam int DW = 24;
  localparam int SPAN = 2 * (DW + 2);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_ready, sclk_o, sdat_o;

  int checks = 0;
  int failures = 0;

  always #(CLK_P/2) clk = ~clk;

  ewb_serializer #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .sclk_o(sclk_o), .sdat_o(sdat_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Called at the falling edge right after a transfer edge. Records the whole
  // frame, drives the next input after the first sample, and checks R1..R7.
  task automatic capture_frame(input logic [DW-1:0] w, input logic [DW-1:0] nxt_data,
                               input logic nxt_valid);
    logic [SPAN-1:0] sc, sd, rdy;
    logic [DW-1:0]   got;
    logic [SPAN-1:0] exp_sc;
    int              bad5;
    for (int j = 0; j < SPAN; j++) begin
      sc[j] = sclk_o; sd[j] = sdat_o; rdy[j] = in_ready;
      if (j == 0) begin in_data = nxt_data; in_valid = nxt_valid; end
      if (j < SPAN - 1) @(negedge clk);
    end
    for (int b = 0; b < DW; b++) got[b] = sd[2*b];
    check(got == w, "R1", "data bits", {8'h0, got}, {8'h0, w});
    check(sd[2*DW] == ~w[DW-1] && sd[2*DW+1] == ~w[DW-1], "R2", "bit25",
          {31'h0, sd[2*DW]}, {31'h0, ~w[DW-1]});
    check(sd[2*DW+2] == w[DW-1] && sd[2*DW+3] == w[DW-1], "R3", "bit26",
          {31'h0, sd[2*DW+2]}, {31'h0, w[DW-1]});
    for (int j = 0; j < SPAN; j++) exp_sc[j] = (j % 2 == 1) || (j >= 2*DW);
    check(sc == exp_sc, "R4", "sclk pattern low word", sc[31:0], exp_sc[31:0]);
    bad5 = 0;
    for (int j = 1; j < SPAN; j++) begin
      if (sd[j] != sd[j-1]) begin
        if (j < 2*DW && !(sc[j] == 1'b0 && sc[j-1] == 1'b1)) bad5++;
        if (j >= 2*DW && !sc[j]) bad5++;
      end
    end
    check(bad5 == 0 && sd[2*DW] != sd[2*DW-1] && sd[2*DW+2] != sd[2*DW+1],
          "R5", "edge placement errors", bad5, 0);
    check(rdy[SPAN-2:0] == '0, "R6", "ready during frame", rdy[31:0], 32'h0);
    check(rdy[SPAN-1] == 1'b1, "R7", "ready in last cycle", {31'h0, rdy[SPAN-1]}, 1);
    @(negedge clk);
  endtask

  task automatic start_word(input logic [DW-1:0] w);
    in_data = w; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    check(sclk_o == 1'b1 && sdat_o == 1'b0, "R10", "line after reset",
          {30'h0, sclk_o, sdat_o}, 32'h2);
    check(in_ready == 1'b0, "R10", "ready with en low", {31'h0, in_ready}, 0);
    en = 1'b1; #1;
    check(in_ready == 1'b1, "R10", "ready with en high", {31'h0, in_ready}, 1);
    @(negedge clk);
  endtask

  task automatic t_single(input logic [DW-1:0] w);
    start_word(w);
    capture_frame(w, ~w, 1'b0);
  endtask

  task automatic t_back_to_back;
    logic [DW-1:0] a = 24'h3C_91E7, b = 24'hC4_0D52, c = 24'h1F_00AB;
    start_word(a);
    capture_frame(a, b, 1'b1);
    capture_frame(b, c, 1'b1);
    capture_frame(c, 24'h00_0000, 1'b0);
  endtask

  task automatic t_idle;
    for (int k = 0; k < 6; k++) begin
      check(sclk_o && !sdat_o && in_ready, "R8", "idle line",
            {29'h0, sclk_o, sdat_o, in_ready}, 32'h5);
      @(negedge clk);
    end
  endtask

  task automatic t_disable;
    start_word(24'hFFFF_FF);
    in_valid = 1'b0;
    repeat (9) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check(sclk_o && !sdat_o && !in_ready, "R9", "abort to idle",
          {29'h0, sclk_o, sdat_o, in_ready}, 32'h4);
    in_valid = 1'b1; in_data = 24'h55_5555;
    for (int k = 0; k < 8; k++) begin
      check(sclk_o && !sdat_o && !in_ready, "R9", "held off",
            {29'h0, sclk_o, sdat_o, in_ready}, 32'h4);
      @(negedge clk);
    end
    in_valid = 1'b0; en = 1'b1;
    @(negedge clk);
    t_single(24'h80_0001);
  endtask

  initial begin
    #(CLK_P * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_single(24'hA5_C3F1);
    t_single(24'h5A_3C0E);
    t_single(24'h00_0000);
    t_single(24'hFF_FFFF);
    t_idle;
    t_back_to_back;
    t_idle;
    t_disable;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule